// File: doc/BRIEF.md
# Windowed Permutation Hypervector Encoder

This block turns a vector of quantized features into an integer hypervector, using rotation as the binding step. Every feature arrives as a small level index. The index picks one of several fixed binary level patterns, and the block keeps those patterns on chip. Feature k contributes its chosen pattern rotated by k positions. Each output dimension is the number of set bits that land on it across all features.

The block does not rotate every feature in full. It walks the output a group of several dimensions at a time. For each group it reads one short wrap-around window of consecutive pattern bits from each level pattern. Every feature steers its own window, and each lane of the group is a popcount over a diagonal of those windows. Groups leave on a valid/ready stream in increasing dimension order. The last group carries a flag, and any lane beyond the final dimension is masked off. A new feature vector is taken only once the previous one has been fully streamed out.

Top module: `hv_perm_encoder`

## Requirements
- R1: While reset is held and right after it, out_valid is 0 and in_ready is 1.
- R2: Bit p of level pattern l is 1 exactly when ((p*(2*l+3)) + floor(p/16)) mod 5 is below 2.
- R3: Feature k takes its level index from in_levels[k*LW +: LW]. The count of dimension j is the sum over features k of bit (j-k) mod DIM of that feature's level pattern, so pattern bit indices wrap from 0 back to DIM-1. The count of lane s sits in out_counts[s*CW +: CW].
- R4: After a vector is accepted, groups appear with out_base equal to 0, GROUP, 2*GROUP and so on. Lane s of a group carries dimension out_base+s.
- R5: out_last is 1 only on the group whose out_base is (ceil(DIM/GROUP)-1)*GROUP, and that group is the last one sent for the vector.
- R6: A lane whose dimension is DIM or more has out_mask bit 0 and count 0. Every other lane of a valid group has out_mask bit 1.
- R7: From the acceptance of a vector until the cycle after its last group's handshake, in_ready is 0, and in_valid and in_levels have no effect on the groups being sent.
- R8: While out_valid is 1 and out_ready is 0, the outputs hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A feature vector is offered |
| in_ready | output | 1 | The block can accept a vector |
| in_levels | input | NFEAT*LW | Level index of each feature |
| out_valid | output | 1 | A group of counts is offered |
| out_ready | input | 1 | The consumer takes the group |
| out_counts | output | GROUP*CW | Per-lane dimension counts |
| out_mask | output | GROUP | Lane holds a real dimension |
| out_base | output | DIMW | Dimension index of lane 0 |
| out_last | output | 1 | Final group of the vector |

## Verification
The bench drives all sixteen level combinations of the four features and checks every group of each result against counts computed arithmetically.

- **Uniform vectors.** All-zero and all-one inputs isolate each level pattern on its own.
- **Mixed vectors.** These show whether each feature's window is steered by its own index and rotated by its own offset.
- **Wrap and tail groups.** The first group reads bits at the top of the patterns, and the tail group of the 1000-dimension default has masked lanes. Together they separate correct modular indexing from off-by-one wrap errors.
- **Stalls and held inputs.** A stall pattern on out_ready checks that groups are held and never skipped. A conflicting vector held on the input during each stream shows that a busy block ignores it.

// File: rtl/hv_perm_encoder_pkg.sv
// Package: shared helpers for the permutation encoder.
// Holds the level pattern rule and the wrap-around index arithmetic.
package hv_perm_encoder_pkg;

    // Deterministic bit of level pattern lvl at position pos.
    function automatic logic level_bit(input int lvl, input int pos);
        return (((pos * (2 * lvl + 3)) + (pos / 16)) % 5) < 2;
    endfunction

    // Position (base + off - back) folded into 0..dim-1; assumes base < dim.
    function automatic int wrap_pos(input int base, input int off,
                                    input int back, input int dim);
        int v;
        v = base + off + dim - back;
        if (v >= dim) v = v - dim;
        if (v >= dim) v = v - dim;
        return v;
    endfunction

endpackage

// File: rtl/hv_window_fetch.sv
// Module: hv_window_fetch
// Holds one constant level pattern and reads a window of WIN consecutive
// bits from it, starting BACK positions below base, with wrap-around.
// Assumes base < DIM and WIN + BACK well below DIM.
module hv_window_fetch #(
    parameter int DIM   = 1000,
    parameter int WIN   = 6,
    parameter int BACK  = 3,
    parameter int LEVEL = 0,
    localparam int DIMW = $clog2(DIM)
) (
    input  logic [DIMW-1:0] base,
    output logic [WIN-1:0]  win
);
    import hv_perm_encoder_pkg::*;

    // Build the full level pattern once at elaboration.
    function automatic logic [DIM-1:0] build_pattern();
        logic [DIM-1:0] p;
        for (int i = 0; i < DIM; i++) p[i] = level_bit(LEVEL, i);
        return p;
    endfunction

    localparam logic [DIM-1:0] PATTERN = build_pattern();

    for (genvar o = 0; o < WIN; o++) begin : g_tap
        // Select the pattern bit for window offset o.
        always_comb begin
            int idx;
            idx = wrap_pos(int'(base), o, BACK, DIM);
            win[o] = PATTERN[DIMW'(idx)];
        end
    end
endmodule

// File: rtl/hv_lane_count.sv
// Module: hv_lane_count
// Counts the set bits on one diagonal of the per-feature windows.
// Feature k contributes window bit LANE - k + NFEAT - 1, which is
// pattern position (dimension - k).
module hv_lane_count #(
    parameter int NFEAT = 4,
    parameter int WIN   = 6,
    parameter int LANE  = 0,
    localparam int CW   = $clog2(NFEAT + 1)
) (
    input  logic [NFEAT*WIN-1:0] feat_win,
    output logic [CW-1:0]        count
);
    // Sum one tap from each feature window.
    always_comb begin
        count = '0;
        for (int k = 0; k < NFEAT; k++)
            count = count + CW'(feat_win[k*WIN + LANE - k + NFEAT - 1]);
    end
endmodule

// File: rtl/hv_perm_encoder.sv
// Module: hv_perm_encoder (top)
// Encodes NFEAT level indices into DIM per-dimension counts, streamed
// GROUP dimensions per beat. Feature k is rotated by k positions.
// Assumes GROUP + NFEAT - 1 < DIM and a synchronous active-low reset.
module hv_perm_encoder #(
    parameter int DIM    = 1000,
    parameter int GROUP  = 3,
    parameter int NFEAT  = 4,
    parameter int NLEVEL = 2,
    localparam int LW    = (NLEVEL > 1) ? $clog2(NLEVEL) : 1,
    localparam int CW    = $clog2(NFEAT + 1),
    localparam int DIMW  = $clog2(DIM)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [NFEAT*LW-1:0]   in_levels,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [GROUP*CW-1:0]   out_counts,
    output logic [GROUP-1:0]      out_mask,
    output logic [DIMW-1:0]       out_base,
    output logic                  out_last
);
    localparam int WIN       = GROUP + NFEAT - 1;
    localparam int NGROUP    = (DIM + GROUP - 1) / GROUP;
    localparam int LAST_BASE = (NGROUP - 1) * GROUP;

    logic                busy_q;
    logic [DIMW-1:0]     base_q;
    logic [NFEAT*LW-1:0] lvl_q;
    logic [WIN-1:0]      lvl_win [NLEVEL];
    logic [NFEAT*WIN-1:0] feat_win;
    logic                at_last;

    // One window per level pattern, all at the same base.
    for (genvar l = 0; l < NLEVEL; l++) begin : g_level
        hv_window_fetch #(.DIM(DIM), .WIN(WIN), .BACK(NFEAT - 1), .LEVEL(l))
            u_fetch (.base(base_q), .win(lvl_win[l]));
    end

    // Each feature steers the window of its own level.
    for (genvar k = 0; k < NFEAT; k++) begin : g_feat
        always_comb begin
            int sel;
            sel = int'(lvl_q[k*LW +: LW]);
            if (sel >= NLEVEL) sel = 0;
            feat_win[k*WIN +: WIN] = lvl_win[sel];
        end
    end

    // Per-lane counting and tail masking.
    for (genvar s = 0; s < GROUP; s++) begin : g_lane
        logic [CW-1:0] raw;
        logic          live;
        hv_lane_count #(.NFEAT(NFEAT), .WIN(WIN), .LANE(s))
            u_count (.feat_win(feat_win), .count(raw));
        assign live = busy_q && ((int'(base_q) + s) < DIM);
        assign out_mask[s] = live;
        assign out_counts[s*CW +: CW] = live ? raw : '0;
    end

    assign at_last   = (base_q == DIMW'(LAST_BASE));
    assign in_ready  = !busy_q;
    assign out_valid = busy_q;
    assign out_base  = base_q;
    assign out_last  = busy_q && at_last;

    // Accept a vector when idle and step through groups on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            base_q <= '0;
            lvl_q  <= '0;
        end else if (!busy_q) begin
            if (in_valid) begin
                busy_q <= 1'b1;
                base_q <= '0;
                lvl_q  <= in_levels;
            end
        end else if (out_ready) begin
            if (at_last) begin
                busy_q <= 1'b0;
                base_q <= '0;
            end else begin
                base_q <= base_q + DIMW'(GROUP);
            end
        end
    end
endmodule

// File: rtl/hv_perm_encoder_chk.sv
// Module: hv_perm_encoder_chk
// Checks the stream protocol and the group sequence of hv_perm_encoder.
// It is bound into every instance of the top module.
module hv_perm_encoder_chk #(
    parameter int DIM    = 1000,
    parameter int GROUP  = 3,
    parameter int NFEAT  = 4,
    localparam int CW    = $clog2(NFEAT + 1),
    localparam int DIMW  = $clog2(DIM)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [GROUP*CW-1:0] out_counts,
    input logic [GROUP-1:0]    out_mask,
    input logic [DIMW-1:0]     out_base,
    input logic                out_last
);
    localparam int NGROUP    = (DIM + GROUP - 1) / GROUP;
    localparam int LAST_BASE = (NGROUP - 1) * GROUP;

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> !out_valid && in_ready);                            // R1
    AST_FIRST_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_base == '0);         // R4
    AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last
        |=> out_valid && out_base == $past(out_base) + DIMW'(GROUP));  // R4
    AST_LAST_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> out_base == DIMW'(LAST_BASE));       // R5
    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid && in_ready); // R5
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);                                      // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_base)
        && $stable(out_counts) && $stable(out_mask)
        && $stable(out_last));                                         // R8

    for (genvar s = 0; s < GROUP; s++) begin : g_lane_chk
        AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && !out_mask[s] |-> out_counts[s*CW +: CW] == '0); // R6
        AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> int'(out_counts[s*CW +: CW]) <= NFEAT);        // R3
    end
endmodule

bind hv_perm_encoder hv_perm_encoder_chk #(
    .DIM(DIM), .GROUP(GROUP), .NFEAT(NFEAT)
) u_chk (.*);

// File: tb/tb_hv_perm_encoder.sv
// Bench: every level combination, a stall pattern on out_ready, and a
// conflicting vector held on the input while the block is busy.
module tb_hv_perm_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int DIM    = 1000;
    localparam int GROUP  = 3;
    localparam int NFEAT  = 4;
    localparam int NLEVEL = 2;
    localparam int LW     = 1;
    localparam int CW     = 3;
    localparam int DIMW   = 10;
    localparam int NGROUP = (DIM + GROUP - 1) / GROUP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [NFEAT*LW-1:0] in_levels = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [GROUP*CW-1:0] out_counts;
    logic [GROUP-1:0] out_mask;
    logic [DIMW-1:0] out_base;
    logic out_last;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    hv_perm_encoder #(.DIM(DIM), .GROUP(GROUP), .NFEAT(NFEAT), .NLEVEL(NLEVEL)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_levels(in_levels), .out_valid(out_valid), .out_ready(out_ready),
        .out_counts(out_counts), .out_mask(out_mask), .out_base(out_base),
        .out_last(out_last));

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2 rule for bit p of level l.
    function automatic int pat(input int l, input int p);
        return ((((p * (2 * l + 3)) + (p / 16)) % 5) < 2) ? 1 : 0;
    endfunction

    // R3 expected count of dimension j for vector v.
    function automatic int expect_count(input int v, input int j);
        int sum = 0;
        for (int k = 0; k < NFEAT; k++)
            sum += pat((v >> (k * LW)) & 1, (j - k + DIM) % DIM);
        return sum;
    endfunction

    task automatic run_vector(input int v);
        int g = 0;
        int prev_base = -1;
        bit stalled = 1'b0;
        @(negedge clk);
        in_valid  = 1'b1;
        in_levels = (NFEAT*LW)'(v);
        chk(in_ready == 1'b1, "R7 ready when idle", int'(in_ready), 1);
        @(negedge clk);
        in_levels = (NFEAT*LW)'(~v);  // R7: must be ignored while busy
        while (g < NGROUP) begin
            bit rdy;
            rdy = ((cyc * 5 + v) % 7) != 0;
            out_ready = rdy;
            chk(out_valid == 1'b1, "R4 valid", int'(out_valid), 1);
            chk(int'(out_base) == g * GROUP, "R4 base", int'(out_base), g * GROUP);
            if (stalled)
                chk(int'(out_base) == prev_base, "R8 held", int'(out_base), prev_base);
            chk(out_last == (g == NGROUP - 1), "R5 last", int'(out_last), int'(g == NGROUP - 1));
            chk(in_ready == 1'b0, "R7 busy", int'(in_ready), 0);
            for (int s = 0; s < GROUP; s++) begin
                int j;
                int e;
                int a;
                j = g * GROUP + s;
                e = (j < DIM) ? expect_count(v, j) : 0;
                a = int'(out_counts[s*CW +: CW]);
                chk(a == e, (j < DIM) ? "R2/R3 count" : "R6 masked count", a, e);
                chk(out_mask[s] == (j < DIM), "R6 mask", int'(out_mask[s]), int'(j < DIM));
            end
            stalled   = !rdy;
            prev_base = int'(out_base);
            cyc++;
            @(negedge clk);
            if (rdy) g++;
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R5 done", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R7 free", int'(in_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        for (int v = 0; v < (1 << (NFEAT * LW)); v++) run_vector(v);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule